// File: doc/BRIEF.md
# Serial-In Parallel-Out Shift and Hold Output Stage

This block turns a slow serial bit stream into an 8-bit parallel output word. An external controller presents one bit at a time on a serial data pin and pulses a shift clock. Each rising edge of that shift clock pushes the bit into an internal shift register. A separate hold stage sits between the shift register and the outputs. While the active-low strobe is asserted, the hold stage passes the register contents through and keeps following them. While the strobe is deasserted, the outputs are frozen.

An active-low clear empties the hold stage at once and forces every output low, whatever the other pins are doing. The clear has no effect on the shift register, which keeps its contents and keeps accepting bits. When the clear is released with the strobe asserted, the current register contents show up on the outputs again.

All four control and data pins are asynchronous to the fast system clock. They are brought in through two-flop synchronizers, and the shift clock's rising edge is found by edge detection. The clear also reaches the hold stage directly, so it takes effect without waiting for a clock edge.

Top module: `sipo_latch_driver`

## Requirements
- R1: After power-on reset (`rst_ni` low), both the shift register and the hold stage are zero, so `out_o` reads 0 even once the strobe is asserted.
- R2: Each rising edge of `shift_clk_i` shifts `ser_data_i` into bit 0 and moves every stored bit up by one position. After eight edges, the first bit is at bit 7 (`out_o[7]`) and the most recent bit is at bit 0. Falling edges shift nothing.
- R3: While `strobe_ni` is low and `clear_ni` is high, `out_o` follows the shift register, including shifts that happen while the strobe stays low.
- R4: While `strobe_ni` is high, `out_o` keeps its value no matter how many bits are shifted in.
- R5: While `clear_ni` is low, `out_o` is 0, whatever the strobe, data and shift clock are doing. The outputs drop before the next system clock edge.
- R6: `clear_ni` does not touch the shift register. Bits shifted in while the clear is low are kept, and after release with the strobe low, `out_o` shows the full current contents.
- R7: With the strobe low, a shift clock rising edge that is set up before system clock edge k changes `out_o` right after edge k+3, and not before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast system clock |
| rst_ni | input | 1 | Active-low power-on reset, asynchronous |
| ser_data_i | input | 1 | Serial data bit, asynchronous |
| shift_clk_i | input | 1 | Shift clock; data is taken on its rising edge |
| strobe_ni | input | 1 | Active-low strobe; low makes the hold stage transparent |
| clear_ni | input | 1 | Active-low clear of the hold stage and the outputs |
| out_o | output | 8 | Parallel output word; bit 7 holds the oldest bit |

## Verification
Every one of the 256 byte values is shifted in with the strobe high and then strobed out. This exercises the bit ordering and also shows that the previous word stays frozen during shifting. Words are also shifted in with the strobe held low, with the outputs compared after every bit, to tell real transparency apart from loading only at strobe time. A single edge is timed cycle by cycle to pin down the latency. A clear pulse that arrives during shifting, with the strobe asserted, separates a clear that affects only the hold stage from one that would also wipe the register.

// File: rtl/sipo_pkg.sv
package sipo_pkg;
    localparam int unsigned SYNC_STAGES = 2;
    // positions inside the synchronized input bus
    localparam int unsigned IDX_SCLK = 0;
    localparam int unsigned IDX_DATA = 1;
    localparam int unsigned IDX_STRB = 2;
    localparam int unsigned IDX_CLR  = 3;
    localparam int unsigned NUM_SYNC = 4;
endpackage

// File: rtl/sipo_sync.sv
module sipo_sync #(
    parameter int unsigned N       = 4,
    parameter int unsigned STAGES  = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] sync_o
);
    typedef struct packed {
        logic [STAGES-1:0][N-1:0] chain;
    } state_t;

    state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        state_d.chain[0] = async_i;
        for (int s = 1; s < int'(STAGES); s++) begin
            state_d.chain[s] = state_q.chain[s-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= {STAGES{RST_VAL}};
        end else begin
            state_q <= state_d;
        end
    end

    assign sync_o = state_q.chain[STAGES-1];
endmodule

// File: rtl/sipo_shift.sv
module sipo_shift #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             sclk_i,
    input  logic             din_i,
    output logic [WIDTH-1:0] shift_o
);
    typedef struct packed {
        logic             sclk_prev;
        logic [WIDTH-1:0] sr;
    } state_t;

    state_t state_d, state_q;
    logic   edge_pulse;

    assign edge_pulse = sclk_i & ~state_q.sclk_prev;

    always_comb begin
        state_d           = state_q;
        state_d.sclk_prev = sclk_i;
        if (edge_pulse) begin
            state_d.sr = {state_q.sr[WIDTH-2:0], din_i};
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q.sclk_prev <= 1'b1;
            state_q.sr        <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign shift_o = state_q.sr;

    // R2
    shift_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        edge_pulse |=> (shift_o == {$past(shift_o[WIDTH-2:0]), $past(din_i)}));
    // R2
    shift_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !edge_pulse |=> $stable(shift_o));
    // R7
    pulse_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        edge_pulse |=> !edge_pulse);
endmodule

// File: rtl/sipo_hold.sv
module sipo_hold #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_async_ni,
    input  logic             clr_sync_ni,
    input  logic             strb_sync_ni,
    input  logic [WIDTH-1:0] shift_i,
    output logic [WIDTH-1:0] out_o
);
    typedef struct packed {
        logic [WIDTH-1:0] word;
    } state_t;

    state_t state_d, state_q;
    logic   hold_rst_n;

    // assert at once from the pin, release only after the synchronized copy
    assign hold_rst_n = rst_ni & clr_async_ni & clr_sync_ni;

    always_comb begin
        state_d = state_q;
        if (!strb_sync_ni) begin
            state_d.word = shift_i;
        end
    end

    always_ff @(posedge clk_i or negedge hold_rst_n) begin
        if (!hold_rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_o = state_q.word;

    // R5
    clear_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !clr_async_ni |-> (out_o == '0));
    // R4
    hold_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (strb_sync_ni && hold_rst_n) |=> (!hold_rst_n || out_o == $past(out_o)));
    // R3
    pass_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!strb_sync_ni && hold_rst_n) |=> (!hold_rst_n || out_o == $past(shift_i)));
endmodule

// File: rtl/sipo_latch_driver.sv
module sipo_latch_driver #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             ser_data_i,
    input  logic             shift_clk_i,
    input  logic             strobe_ni,
    input  logic             clear_ni,
    output logic [WIDTH-1:0] out_o
);
    import sipo_pkg::*;

    localparam logic [NUM_SYNC-1:0] SYNC_RST = (NUM_SYNC)'(
        (1 << IDX_SCLK) | (1 << IDX_STRB) | (1 << IDX_CLR));

    logic [NUM_SYNC-1:0] raw_in;
    logic [NUM_SYNC-1:0] syn_in;
    logic [WIDTH-1:0]    shift_w;

    always_comb begin
        raw_in           = '0;
        raw_in[IDX_SCLK] = shift_clk_i;
        raw_in[IDX_DATA] = ser_data_i;
        raw_in[IDX_STRB] = strobe_ni;
        raw_in[IDX_CLR]  = clear_ni;
    end

    sipo_sync #(
        .N      (NUM_SYNC),
        .STAGES (SYNC_STAGES),
        .RST_VAL(SYNC_RST)
    ) i_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .async_i(raw_in),
        .sync_o (syn_in)
    );

    sipo_shift #(.WIDTH(WIDTH)) i_shift (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .sclk_i (syn_in[IDX_SCLK]),
        .din_i  (syn_in[IDX_DATA]),
        .shift_o(shift_w)
    );

    sipo_hold #(.WIDTH(WIDTH)) i_hold (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .clr_async_ni(clear_ni),
        .clr_sync_ni (syn_in[IDX_CLR]),
        .strb_sync_ni(syn_in[IDX_STRB]),
        .shift_i     (shift_w),
        .out_o       (out_o)
    );
endmodule

// File: tb/test_sipo_latch_driver.sv
module test_sipo_latch_driver;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       data = 1'b0;
    logic       sclk = 1'b0;
    logic       strb_n = 1'b1;
    logic       clr_n = 1'b1;
    logic [7:0] out;
    int         n_chk = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    sipo_latch_driver i_sipo_latch_driver (
        .clk_i(clk), .rst_ni(rst_n), .ser_data_i(data), .shift_clk_i(sclk),
        .strobe_ni(strb_n), .clear_ni(clr_n), .out_o(out)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: out=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic shift_bit(input logic b);
        @(negedge clk);
        data = b;
        wait_cyc(2);
        sclk = 1'b1;
        wait_cyc(4);
        sclk = 1'b0;
        wait_cyc(4);
    endtask

    task automatic shift_word(input logic [7:0] w);
        for (int i = 7; i >= 0; i--) shift_bit(w[i]);
    endtask

    initial begin
        logic [7:0] model;
        logic [7:0] prev;
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(2);
        // R1: reset state, then strobe shows an empty register
        check("R1", out, 8'h00);
        strb_n = 1'b0;
        wait_cyc(6);
        check("R1", out, 8'h00);
        strb_n = 1'b1;
        wait_cyc(4);

        // R2 / R4: all byte values, frozen while shifting, then strobed
        prev = 8'h00;
        for (int w = 0; w < 256; w++) begin
            shift_word(8'(w));
            check("R4", out, prev);
            strb_n = 1'b0;
            wait_cyc(6);
            check("R2", out, 8'(w));
            strb_n = 1'b1;
            wait_cyc(4);
            prev = 8'(w);
        end

        // R3: transparent while strobe stays low, following each shift
        model = 8'hFF;
        strb_n = 1'b0;
        wait_cyc(4);
        foreach (model[i]) begin end
        for (int k = 0; k < 16; k++) begin
            logic b;
            b = ((k * 5) % 3) == 0;
            shift_bit(b);
            model = {model[6:0], b};
            check("R3", out, model);
        end

        // R7: exact latency of one edge with strobe low
        @(negedge clk);
        data = ~model[0];
        wait_cyc(3);
        sclk = 1'b1;
        repeat (3) @(posedge clk);
        #1 check("R7", out, model);
        @(posedge clk);
        #1 check("R7", out, {model[6:0], ~model[0]});
        model = {model[6:0], ~model[0]};
        wait_cyc(4);
        sclk = 1'b0;
        wait_cyc(4);

        // R5: clear drops outputs before the next clock edge
        @(negedge clk);
        clr_n = 1'b0;
        #1 check("R5", out, 8'h00);
        // R6: shifting continues during clear, strobe low throughout
        shift_word(8'hA6);
        check("R5", out, 8'h00);
        strb_n = 1'b1;
        wait_cyc(4);
        strb_n = 1'b0;
        wait_cyc(4);
        check("R5", out, 8'h00);
        clr_n = 1'b1;
        wait_cyc(6);
        check("R6", out, 8'hA6);

        // R6: partial shift during clear keeps older bits
        clr_n = 1'b0;
        wait_cyc(2);
        shift_bit(1'b0);
        shift_bit(1'b1);
        check("R5", out, 8'h00);
        clr_n = 1'b1;
        wait_cyc(6);
        check("R6", out, 8'h99);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: out=%02h expected=done", out);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule